// File: doc/BRIEF.md
# SMBus Byte-Register Target with Stop-Committed Writes

This block is a two-wire bus target. It sits behind oversampled SCL and SDA inputs and gives a controller access to four 8-bit control registers. The controller writes a register with the Write Byte transfer: address with write, command, data, then STOP. It reads a register with the Read Byte transfer: address with write, command, repeated START, address with read, one data byte returned, NACK, then STOP. The two lowest bits of the command byte select the register. The six bits above them are ignored.

A write is staged when its data byte is acknowledged. It reaches the register only when a STOP ends the transfer. A repeated START that arrives first drops the staged data. The block also acknowledges a broadcast write address, which a bit in register 2 can disable. While its alert output is asserted, it answers the alert response address with its own address byte and then releases the alert. Both bus lines pass through glitch filters that run on the system clock. The block pulls SDA low for ACK and for zero read bits. It never stretches the clock.

Top module: `smb_regslave`

## Requirements
- R1: The device address is the 7-bit value {1001, addr_pins[2:0]}. A Write Byte to it is acknowledged on the address, command and data bytes. It stores the data byte in register cmd[1:0], and command bits 7..2 have no effect. Register k appears on regs_flat[8k+7:8k].
- R2: After the data byte of a write is acknowledged, regs_flat stays unchanged until the STOP condition.
- R3: If a repeated START follows the data byte of a write before any STOP, the staged data is discarded and all registers keep their values.
- R4: A Read Byte to the device address is acknowledged on both address bytes and on the command byte. It returns register cmd[1:0] MSB first. SDA is released for the controller's acknowledge bit.
- R5: An address byte that matches none of the accepted addresses is not acknowledged. The block then ignores the bus until the next START, so the command and data bytes that follow are not acknowledged and no register changes.
- R6: The broadcast address 0101100 with write is acknowledged and written like the device address while bit 0 of register 2 (broadcast enable) is 1. It is not acknowledged while that bit is 0. A read to the broadcast address is never acknowledged.
- R7: A rising edge on alert_req drives alert_n low. A read to address 0001100 is acknowledged only while alert_n is low. It returns {device address, 0}, and once that byte is sent alert_n returns high.
- R8: A pulse shorter than FILT_LEN system clocks on SCL or SDA has no effect: no extra bit is clocked and no START or STOP is seen.
- R9: After reset, registers 0, 1 and 3 are 0x00, register 2 is 0x01, sda_oe is 0 and alert_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level (wired bus value) |
| addr_pins | input | 3 | Low bits of the device address |
| alert_req | input | 1 | Alert request, rising edge sets the pending alert |
| sda_oe | output | 1 | 1 pulls SDA low |
| alert_n | output | 1 | Active-low alert output |
| regs_flat | output | 32 | The four control registers, register k at bits 8k+7..8k |

## Verification
The hardest case to reach from the ports is a data byte that has been acknowledged and staged but not yet committed. The bench stops inside that window to check that the registers are unchanged. It then ends the transfer once with STOP and once with a repeated START that leads into a read. The read then returns the old value. For the filter, one write drives every bit with a sub-threshold SCL pulse in the low phase and a sub-threshold SDA dip in the high phase. If either pulse got through, it would add a bit or fake a START, and the committed value would show it. The alert case walks the pending flag through a refused response read, a rising edge on the request input, an accepted read and the release of alert_n.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam int MWE_BIT = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_WDATA, S_HOLD, S_RDATA, S_SKIP
  } bus_state_t;

  // reset value of control register idx
  function automatic logic [BYTE_W-1:0] reg_reset_val(input int idx);
    return (idx == 2) ? BYTE_W'(1 << MWE_BIT) : '0;
  endfunction

  // fixed address bits from base, low bits from the pins
  function automatic logic [6:0] merge_addr(input logic [6:0] base,
                                            input logic [6:0] pins,
                                            input logic [6:0] mask);
    return (base & ~mask) | (pins & mask);
  endfunction

  // SDA pull-down for read bit idx (0 = MSB)
  function automatic logic pull_for_bit(input logic [BYTE_W-1:0] b,
                                        input logic [3:0] idx);
    return ~b[3'd7 - idx[2:0]];
  endfunction
endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt   <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == filt) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        filt  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R8: the filtered level only moves toward a level actually sampled
  a_r8_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(sync_q[1]) == filt));

  // R8: a change is preceded by a run of differing samples
  a_r8_run_before_change: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(run_q) == CW'(FILT_LEN - 1)));
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_ev  = scl & scl_d & ~sda_d & sda;

  // R5: at most one bus event per clock
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_pkg::*; #(
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [SEL_W-1:0]           sel,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
  output logic                       mass_en
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_flat[k*BYTE_W +: BYTE_W] <= reg_reset_val(k);
      else if (commit && (int'(sel) == k))
        regs_flat[k*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  assign mass_en = regs_flat[2*BYTE_W + MWE_BIT];

  // R2: no register changes without a commit strobe
  a_r2_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_flat));
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave import smb_pkg::*; #(
  parameter int         FILT_LEN  = 4,
  parameter int         PIN_W     = 3,
  parameter logic [6:0] ADDR_BASE = 7'b1001000,
  parameter logic [6:0] MASS_ADDR = 7'b0101100,
  parameter int         NUM_REGS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  input  logic [PIN_W-1:0]           addr_pins,
  input  logic                       alert_req,
  output logic                       sda_oe,
  output logic                       alert_n,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  localparam int         SEL_W    = $clog2(NUM_REGS);
  localparam logic [6:0] PIN_MASK = 7'((1 << PIN_W) - 1);

  logic [1:0] raw_lines, filt_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    smb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .filt(filt_lines[g]));
  end

  smb_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl(filt_lines[1]), .sda(filt_lines[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  bus_state_t        state, nxt_q, nxt;
  logic [3:0]        bitcnt;
  logic              ackph, ara_rd, alert_pend, alert_q;
  logic [BYTE_W-1:0] shreg, rbyte, pend_data, rd_val;
  logic [SEL_W-1:0]  sel;
  logic              mass_en, acc, load_rd, set_ara;
  logic [6:0]        own;

  // named internal events
  logic rx_state, byte_done, commit, ara_done, hit_own, hit_mass, hit_ara, rw;
  assign own       = merge_addr(ADDR_BASE, 7'(addr_pins), PIN_MASK);
  assign rw        = shreg[0];
  assign hit_own   = (shreg[7:1] == own);
  assign hit_mass  = (shreg[7:1] == MASS_ADDR);
  assign hit_ara   = (shreg[7:1] == ARA_ADDR);
  assign rx_state  = (state == S_ADDR) || (state == S_CMD) || (state == S_WDATA);
  assign byte_done = rx_state && scl_fall && !ackph && (bitcnt == 4'd8);
  assign commit    = stop_ev && (state == S_HOLD);
  assign ara_done  = (state == S_RDATA) && ara_rd && scl_fall && (bitcnt == 4'd8);

  smb_regfile #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sel(sel), .wdata(pend_data),
    .regs_flat(regs_flat), .mass_en(mass_en));

  // acknowledge decision for the byte just received
  always_comb begin
    acc = 1'b0; nxt = S_SKIP; load_rd = 1'b0; set_ara = 1'b0; rd_val = rbyte;
    case (state)
      S_ADDR: begin
        if (hit_own && !rw) begin
          acc = 1'b1; nxt = S_CMD;
        end else if (hit_own && rw) begin
          acc = 1'b1; nxt = S_RDATA; load_rd = 1'b1;
          rd_val = regs_flat[int'(sel)*BYTE_W +: BYTE_W];
        end else if (hit_mass && !rw && mass_en) begin
          acc = 1'b1; nxt = S_CMD;
        end else if (hit_ara && rw && alert_pend) begin
          acc = 1'b1; nxt = S_RDATA; load_rd = 1'b1; set_ara = 1'b1;
          rd_val = {own, 1'b0};
        end
      end
      S_CMD:   begin acc = 1'b1; nxt = S_WDATA; end
      S_WDATA: begin acc = 1'b1; nxt = S_HOLD;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; nxt_q <= S_IDLE; bitcnt <= '0; ackph <= 1'b0;
      shreg <= '0; rbyte <= '0; pend_data <= '0; sel <= '0;
      sda_oe <= 1'b0; ara_rd <= 1'b0;
    end else if (start_ev) begin
      state <= S_ADDR; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0; ara_rd <= 1'b0;
    end else if (stop_ev) begin
      state <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0; ara_rd <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && !ackph && bitcnt < 4'd8) begin
        shreg  <= {shreg[BYTE_W-2:0], filt_lines[0]};
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall && ackph) begin
        ackph  <= 1'b0;
        bitcnt <= '0;
        state  <= nxt_q;
        sda_oe <= (nxt_q == S_RDATA) ? pull_for_bit(rbyte, 4'd0) : 1'b0;
      end else if (byte_done) begin
        if (acc) begin
          sda_oe <= 1'b1;
          ackph  <= 1'b1;
          nxt_q  <= nxt;
          if (load_rd) rbyte <= rd_val;
          if (set_ara) ara_rd <= 1'b1;
          if (state == S_CMD) sel <= shreg[SEL_W-1:0];
          if (state == S_WDATA) pend_data <= shreg;
        end else begin
          state <= S_SKIP;
        end
      end
    end else if (state == S_RDATA) begin
      if (scl_rise && bitcnt < 4'd8) begin
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          sda_oe <= 1'b0; state <= S_SKIP; ara_rd <= 1'b0;
        end else begin
          sda_oe <= pull_for_bit(rbyte, bitcnt);
        end
      end
    end
  end

  // alert: set on request edge, cleared once the response byte is out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0; alert_pend <= 1'b0;
    end else begin
      alert_q <= alert_req;
      if (ara_done) alert_pend <= 1'b0;
      else if (alert_req && !alert_q) alert_pend <= 1'b1;
    end
  end
  assign alert_n = ~alert_pend;

  // R9: nothing is driven on SDA while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  // R7: an alert-response read only runs while the alert is pending
  a_r7_ara_needs_alert: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RDATA) && ara_rd) |-> alert_pend);

  // R7: the pending alert is cleared only by finishing a response read
  a_r7_clear_by_ara: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pend) |-> ($past(state) == S_RDATA) && $past(ara_rd));

  // R3: a START never lands in the staged-write state
  a_r3_start_drops_stage: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == S_ADDR));
endmodule

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;
  import smb_pkg::*;
  localparam int Q = 12;
  localparam int FILT = 4;
  localparam logic [6:0] MASS = 7'b0101100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, alert_req = 1'b0;
  logic [2:0] pins = 3'd0;
  logic sda_oe, alert_n;
  logic [31:0] regs_flat;
  wire line = sda_m & ~sda_oe;

  smb_regslave u_smb_regslave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line),
    .addr_pins(pins), .alert_req(alert_req),
    .sda_oe(sda_oe), .alert_n(alert_n), .regs_flat(regs_flat));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [4];

  function automatic logic [31:0] packed_exp();
    return {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
  endfunction
  function automatic logic [6:0] own_of(input logic [2:0] p);
    return {4'b1001, p};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic do_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
  endtask
  task automatic put_bit(input logic b, input bit g);
    sda_m = b; wt(Q);
    if (g) begin scl_m = 1'b1; wt(FILT-1); scl_m = 1'b0; wt(Q); end
    scl_m = 1'b1; wt(Q);
    if (g && b) begin sda_m = 1'b0; wt(FILT-1); sda_m = 1'b1; end
    wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, input bit g, output logic ack);
    logic bb;
    for (int i = 7; i >= 0; i--) put_bit(v[i], g);
    get_bit(bb);
    ack = ~bb;
  endtask
  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(1'b1, 1'b0);
  endtask

  // full write; checks staged data is not visible before STOP (R2)
  task automatic write_tx(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                          input bit g, output logic [2:0] acks);
    do_start();
    send_byte({a, 1'b0}, g, acks[2]);
    send_byte(c, g, acks[1]);
    send_byte(d, g, acks[0]);
    wt(Q);
    chk(regs_flat == packed_exp(), "R2 staged write visible before STOP", regs_flat, packed_exp());
    do_stop();
  endtask

  task automatic read_tx(input logic [6:0] a, input logic [7:0] c,
                         output logic [7:0] d, output logic [2:0] acks);
    do_start();
    send_byte({a, 1'b0}, 1'b0, acks[2]);
    send_byte(c, 1'b0, acks[1]);
    do_start();
    send_byte({a, 1'b1}, 1'b0, acks[0]);
    recv_byte(d);
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d, v, c;
    logic ak;
    exp_r[0] = 8'h00; exp_r[1] = 8'h00; exp_r[2] = 8'h01; exp_r[3] = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);

    // R9 reset state
    chk(regs_flat == 32'h0001_0000, "R9 reset registers", regs_flat, 32'h0001_0000);
    chk(sda_oe == 1'b0, "R9 reset sda_oe", 32'(sda_oe), 0);
    chk(alert_n == 1'b1, "R9 reset alert_n", 32'(alert_n), 1);

    // R1/R4 sweep over every pin setting and register
    for (int p = 0; p < 12; p++) begin
      int r = p % 4;
      pins = (p < 8) ? 3'(p) : 3'd5;
      v = 8'(8'h3C ^ (p * 29));
      if (r == 2) v = v | 8'h01;
      c = {6'((p * 7) & 63), 2'(r)};
      write_tx(own_of(pins), c, v, 1'b0, acks);
      chk(acks == 3'b111, "R1 write acks", 32'(acks), 32'h7);
      exp_r[r] = v;
      chk(regs_flat == packed_exp(), "R1 committed register", regs_flat, packed_exp());
      read_tx(own_of(pins), {6'(~p), 2'(r)}, d, acks);
      chk(acks == 3'b111, "R4 read acks", 32'(acks), 32'h7);
      chk(d == exp_r[r], "R4 read data", 32'(d), 32'(exp_r[r]));
    end

    // R5 unmatched address
    pins = 3'd5;
    write_tx(own_of(3'd2), 8'h01, 8'h99, 1'b0, acks);
    chk(acks == 3'b000, "R5 unmatched write acks", 32'(acks), 0);
    chk(regs_flat == packed_exp(), "R5 registers untouched", regs_flat, packed_exp());
    read_tx(own_of(3'd6), 8'h00, d, acks);
    chk(acks[2] == 1'b0, "R5 unmatched read address nack", 32'(acks), 0);

    // R3 repeated START discards staged write
    do_start();
    send_byte({own_of(pins), 1'b0}, 1'b0, acks[2]);
    send_byte(8'hFF, 1'b0, acks[1]);
    send_byte(8'hEE, 1'b0, acks[0]);
    chk(acks == 3'b111, "R3 staged write acks", 32'(acks), 32'h7);
    do_start();
    send_byte({own_of(pins), 1'b1}, 1'b0, ak);
    recv_byte(d);
    do_stop();
    chk(d == exp_r[3], "R3 read after restart returns old", 32'(d), 32'(exp_r[3]));
    chk(regs_flat == packed_exp(), "R3 registers kept", regs_flat, packed_exp());

    // R6 broadcast write enabled
    write_tx(MASS, 8'hA1, 8'hA7, 1'b0, acks);
    exp_r[1] = 8'hA7;
    chk(acks == 3'b111, "R6 broadcast write acks", 32'(acks), 32'h7);
    chk(regs_flat == packed_exp(), "R6 broadcast committed", regs_flat, packed_exp());
    do_start(); send_byte({MASS, 1'b1}, 1'b0, ak); do_stop();
    chk(ak == 1'b0, "R6 broadcast read nack", 32'(ak), 0);
    write_tx(own_of(pins), 8'h02, 8'h80, 1'b0, acks);
    exp_r[2] = 8'h80;
    write_tx(MASS, 8'h00, 8'h11, 1'b0, acks);
    chk(acks[2] == 1'b0, "R6 broadcast disabled nack", 32'(acks), 0);
    chk(regs_flat == packed_exp(), "R6 disabled broadcast ignored", regs_flat, packed_exp());
    write_tx(own_of(pins), 8'h02, 8'h01, 1'b0, acks);
    exp_r[2] = 8'h01;

    // R7 alert response
    do_start(); send_byte({ARA_ADDR, 1'b1}, 1'b0, ak); do_stop();
    chk(ak == 1'b0, "R7 response address nack without alert", 32'(ak), 0);
    alert_req = 1'b1; wt(2); alert_req = 1'b0; wt(8);
    chk(alert_n == 1'b0, "R7 alert asserted", 32'(alert_n), 0);
    do_start(); send_byte({ARA_ADDR, 1'b1}, 1'b0, ak); recv_byte(d); do_stop();
    chk(ak == 1'b1, "R7 response address ack", 32'(ak), 1);
    chk(d == {own_of(pins), 1'b0}, "R7 response byte", 32'(d), 32'({own_of(pins), 1'b0}));
    chk(alert_n == 1'b1, "R7 alert released", 32'(alert_n), 1);

    // R8 sub-threshold pulses on every bit
    write_tx(own_of(pins), 8'h00, 8'b1011_0110, 1'b1, acks);
    exp_r[0] = 8'b1011_0110;
    chk(acks == 3'b111, "R8 glitched write acks", 32'(acks), 32'h7);
    chk(regs_flat == packed_exp(), "R8 glitched write value", regs_flat, packed_exp());

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule